// File: doc/BRIEF.md
# Multi-Mode Output Port Router

This block sits after the channel summers of a multi-carrier transmit path. Each accepted sample brings the real and imaginary parts of four summer results and the real and imaginary cascade totals. The block routes them onto four output lanes of `W` bits each, called A, B, C and D. Lanes A and B are bidirectional. They drive outward when `bidir_oe` is high and are read as cascade inputs when it is low. A mode field, a complex-output bit with a variant selector, and a double-rate bit pick one of eight routings.

The input is a stream qualified by `in_valid`. There is no back-pressure. The pads cannot stall, so the block accepts a sample on every cycle in which `in_valid` is high. It presents that sample one cycle later with `out_valid` high. The lanes hold their last values while no sample arrives. The double-data-rate pad cells are not part of this block. The double-rate mode is modelled with a high-phase vector `lanes_hi` and a low-phase vector `lanes_lo`. Outside that mode both vectors carry the same value.

Top module: `oport_router`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid`, `real_strb` and `bidir_oe` are 0 and both lane vectors are zero.
- R2: A sample taken with `in_valid` high appears on the lanes with `out_valid` high after exactly one clock edge. Without `in_valid`, `out_valid` is 0 and the lanes keep their values.
- R3: With mode field 00 (cascade), `bidir_oe` is 0, lanes A and B carry zero, lane C carries `cas_re` and lane D carries `cas_im`. `port_a_in` and `port_b_in` reach `casc_re_in` and `casc_im_in` only while cascade is selected and `bidir_oe` is low; otherwise those outputs are zero.
- R4: Mode field 01, with the complex and double-rate bits clear, puts the real parts of sums 0..3 on lanes A..D. Mode field 10 puts the imaginary parts on lanes A..D in the same order.
- R5: Mode field 11 interleaves the stream. Accepted samples alternate between real parts (first) and imaginary parts on lanes A..D. With `strb_en` set, `real_strb` is 1 with exactly the real outputs.
- R6: `real_strb` is 0 whenever `strb_en` is 0, and in every mode other than mode field 11.
- R7: A change of the selected routing restarts the interleave, so the first sample accepted in mode 11 after any change is output as real.
- R8: Mode field 01 with the double-rate bit set (and the complex bit clear) outputs every sample: `lanes_hi` holds the real parts of sums 0..3 and `lanes_lo` holds the imaginary parts.
- R9: Mode field 01 with the complex bit set selects by `cplx_sel`. Value 01 gives A,B,C,D = re0, im0, re2, re3. Value 10 gives re0, re1, re2, im2. Values 00 and 11 give re0, im0, re2, im2.
- R10: The complex bit takes precedence over the double-rate bit. Both bits are ignored when the mode field is 00, 10 or 11.
- R11: `bidir_oe` is 1 one cycle after any non-cascade routing is selected.
- R12: Outside double-rate mode, `lanes_lo` equals `lanes_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fld | input | 2 | 00 cascade, 01 real, 10 imaginary, 11 interleaved |
| cplx_en | input | 1 | Complex-output bit (mode field 01 only) |
| cplx_sel | input | 2 | Complex variant selector |
| dbl_rate | input | 1 | Double-rate interleave bit (mode field 01 only) |
| strb_en | input | 1 | Enables the real-sample strobe |
| in_valid | input | 1 | Sample present this cycle |
| sum_re | input | 4*W | Real parts of sums 0..3, sum k at bits k*W |
| sum_im | input | 4*W | Imaginary parts of sums 0..3 |
| cas_re | input | W | Real cascade total |
| cas_im | input | W | Imaginary cascade total |
| port_a_in | input | W | Pad value read on bidirectional lane A |
| port_b_in | input | W | Pad value read on bidirectional lane B |
| casc_re_in | output | W | Cascade real input forwarded to the summer |
| casc_im_in | output | W | Cascade imaginary input forwarded to the summer |
| bidir_oe | output | 1 | Drive enable for lanes A and B |
| out_valid | output | 1 | Lanes carry a new sample |
| real_strb | output | 1 | Lanes carry real data in interleaved mode |
| lanes_hi | output | 4*W | Lane data, lane A at bits 0..W-1; high phase in double-rate mode |
| lanes_lo | output | 4*W | Low-phase lane data |

## Verification
The bench switches into interleaved mode partway through a stream and also switches away from it and back. A design that keeps its phase toggle across a routing change would start with imaginary data and a missing strobe. Each complex variant uses distinct per-sum values. A swapped lane table would put the wrong sum or the wrong part on lane B or lane D. The bench sets the complex and double-rate bits together, and sets either of them in the other modes. A wrong precedence would show up as split hi/lo lanes or as a complex layout. It also checks that the bidirectional enable drops in cascade mode and that pad inputs are not forwarded outside it. A design that gated these wrongly would either drive lanes A and B against incoming cascade data or pass stale pad values into the summation.

// File: rtl/oport_pkg.sv
package oport_pkg;
  typedef enum logic [2:0] {
    RT_CASCADE, RT_REAL, RT_IMAG, RT_MUX, RT_MUX2X, RT_CPX1, RT_CPX2, RT_CPX3
  } route_e;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_RE, SRC_IM, SRC_CRE, SRC_CIM
  } src_kind_e;

  typedef struct packed {
    src_kind_e  kind;
    logic [1:0] idx;
  } src_t;

  localparam int unsigned NUM_LANES = 4;
endpackage

// File: rtl/oport_mode_decode.sv
module oport_mode_decode
  import oport_pkg::*;
(
  input  logic [1:0] mode_fld,
  input  logic       cplx_en,
  input  logic [1:0] cplx_sel,
  input  logic       dbl_rate,
  output route_e     route
);
  always_comb begin
    unique case (mode_fld)
      2'b00: route = RT_CASCADE;
      2'b10: route = RT_IMAG;
      2'b11: route = RT_MUX;
      default: begin
        if (cplx_en) begin
          unique case (cplx_sel)
            2'b01:   route = RT_CPX1;
            2'b10:   route = RT_CPX2;
            default: route = RT_CPX3;
          endcase
        end else if (dbl_rate) begin
          route = RT_MUX2X;
        end else begin
          route = RT_REAL;
        end
      end
    endcase
  end
endmodule

// File: rtl/oport_phase_ctl.sv
module oport_phase_ctl
  import oport_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_e route,
  input  logic   in_valid,
  output logic   ph_imag,
  output logic   route_chg
);
  route_e route_q;
  logic   ph_q;

  assign route_chg = (route != route_q);
  assign ph_imag   = (route == RT_MUX) && !route_chg && ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= RT_CASCADE;
      ph_q    <= 1'b0;
    end else begin
      route_q <= route;
      if (route != RT_MUX)  ph_q <= 1'b0;
      else if (in_valid)    ph_q <= ~ph_imag;
      else if (route_chg)   ph_q <= 1'b0;
    end
  end

  // R5: a real sample in a steady interleave is followed by an imaginary one
  assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && route == RT_MUX && $past(route) == RT_MUX &&
     $past(in_valid) && !$past(ph_imag)) |-> ph_imag);
endmodule

// File: rtl/oport_lane_select.sv
module oport_lane_select
  import oport_pkg::*;
#(
  parameter int unsigned W    = 20,
  parameter int unsigned LANE = 0
) (
  input  route_e                      route,
  input  logic                        ph_imag,
  input  logic [NUM_LANES*W-1:0]      sum_re,
  input  logic [NUM_LANES*W-1:0]      sum_im,
  input  logic [W-1:0]                cas_re,
  input  logic [W-1:0]                cas_im,
  output logic [W-1:0]                hi_d,
  output logic [W-1:0]                lo_d
);
  localparam logic [1:0] LIDX = 2'(LANE);

  function automatic src_t pick(route_e r, logic imag);
    src_t s;
    s.idx  = LIDX;
    s.kind = SRC_RE;
    unique case (r)
      RT_CASCADE: begin
        s.idx  = 2'd0;
        s.kind = (LANE < 2) ? SRC_ZERO : ((LANE == 2) ? SRC_CRE : SRC_CIM);
      end
      RT_REAL:  s.kind = SRC_RE;
      RT_IMAG:  s.kind = SRC_IM;
      RT_MUX, RT_MUX2X: s.kind = imag ? SRC_IM : SRC_RE;
      RT_CPX1: begin
        unique case (LANE)
          0:       begin s.kind = SRC_RE; s.idx = 2'd0; end
          1:       begin s.kind = SRC_IM; s.idx = 2'd0; end
          2:       begin s.kind = SRC_RE; s.idx = 2'd2; end
          default: begin s.kind = SRC_RE; s.idx = 2'd3; end
        endcase
      end
      RT_CPX2: begin
        unique case (LANE)
          0:       begin s.kind = SRC_RE; s.idx = 2'd0; end
          1:       begin s.kind = SRC_RE; s.idx = 2'd1; end
          2:       begin s.kind = SRC_RE; s.idx = 2'd2; end
          default: begin s.kind = SRC_IM; s.idx = 2'd2; end
        endcase
      end
      default: begin
        unique case (LANE)
          0:       begin s.kind = SRC_RE; s.idx = 2'd0; end
          1:       begin s.kind = SRC_IM; s.idx = 2'd0; end
          2:       begin s.kind = SRC_RE; s.idx = 2'd2; end
          default: begin s.kind = SRC_IM; s.idx = 2'd2; end
        endcase
      end
    endcase
    return s;
  endfunction

  function automatic logic [W-1:0] fetch(src_t s, logic [NUM_LANES*W-1:0] re,
                                         logic [NUM_LANES*W-1:0] im,
                                         logic [W-1:0] cre, logic [W-1:0] cim);
    logic [W-1:0] v;
    unique case (s.kind)
      SRC_RE:  v = re[int'(s.idx)*W +: W];
      SRC_IM:  v = im[int'(s.idx)*W +: W];
      SRC_CRE: v = cre;
      SRC_CIM: v = cim;
      default: v = '0;
    endcase
    return v;
  endfunction

  src_t src_hi, src_lo;

  always_comb begin
    src_hi = pick(route, (route == RT_MUX) ? ph_imag : 1'b0);
    src_lo = (route == RT_MUX2X) ? pick(route, 1'b1) : src_hi;
    hi_d   = fetch(src_hi, sum_re, sum_im, cas_re, cas_im);
    lo_d   = fetch(src_lo, sum_re, sum_im, cas_re, cas_im);
  end
endmodule

// File: rtl/oport_router.sv
module oport_router
  import oport_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_fld,
  input  logic                   cplx_en,
  input  logic [1:0]             cplx_sel,
  input  logic                   dbl_rate,
  input  logic                   strb_en,
  input  logic                   in_valid,
  input  logic [4*W-1:0]         sum_re,
  input  logic [4*W-1:0]         sum_im,
  input  logic [W-1:0]           cas_re,
  input  logic [W-1:0]           cas_im,
  input  logic [W-1:0]           port_a_in,
  input  logic [W-1:0]           port_b_in,
  output logic [W-1:0]           casc_re_in,
  output logic [W-1:0]           casc_im_in,
  output logic                   bidir_oe,
  output logic                   out_valid,
  output logic                   real_strb,
  output logic [4*W-1:0]         lanes_hi,
  output logic [4*W-1:0]         lanes_lo
);
  route_e route;
  logic   ph_imag, route_chg;
  logic   oe_q, vld_q, strb_q;

  oport_mode_decode u_dec (
    .mode_fld (mode_fld),
    .cplx_en  (cplx_en),
    .cplx_sel (cplx_sel),
    .dbl_rate (dbl_rate),
    .route    (route)
  );

  oport_phase_ctl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .route     (route),
    .in_valid  (in_valid),
    .ph_imag   (ph_imag),
    .route_chg (route_chg)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [W-1:0] hi_d, lo_d, hq, lq;

    oport_lane_select #(.W(W), .LANE(g)) u_sel (
      .route   (route),
      .ph_imag (ph_imag),
      .sum_re  (sum_re),
      .sum_im  (sum_im),
      .cas_re  (cas_re),
      .cas_im  (cas_im),
      .hi_d    (hi_d),
      .lo_d    (lo_d)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hq <= '0;
        lq <= '0;
      end else if (in_valid) begin
        hq <= hi_d;
        lq <= lo_d;
      end
    end

    assign lanes_hi[g*W +: W] = hq;
    assign lanes_lo[g*W +: W] = lq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      vld_q  <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      oe_q   <= (route != RT_CASCADE);
      vld_q  <= in_valid;
      strb_q <= in_valid && strb_en && (route == RT_MUX) && !ph_imag;
    end
  end

  assign bidir_oe   = oe_q;
  assign out_valid  = vld_q;
  assign real_strb  = strb_q;
  assign casc_re_in = (route == RT_CASCADE && !oe_q) ? port_a_in : '0;
  assign casc_im_in = (route == RT_CASCADE && !oe_q) ? port_b_in : '0;

  assert_oe_cascade_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_CASCADE) |=> !bidir_oe);

  assert_oe_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (route != RT_CASCADE) |=> bidir_oe);

  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(lanes_hi) && $stable(lanes_lo)));

  assert_strb_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    real_strb |-> ($past(strb_en) && out_valid));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && strb_en && route == RT_MUX && route_chg) |=> real_strb);

  assert_lo_equal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(route) != RT_MUX2X && $past(in_valid)) |-> (lanes_lo == lanes_hi));
endmodule

// File: tb/oport_router_test.sv
`timescale 1ns/1ps
module oport_router_test;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode_fld;
  logic cplx_en, dbl_rate, strb_en, in_valid;
  logic [1:0] cplx_sel;
  logic [4*W-1:0] sum_re, sum_im;
  logic [W-1:0] cas_re, cas_im, port_a_in, port_b_in;
  logic [W-1:0] casc_re_in, casc_im_in;
  logic bidir_oe, out_valid, real_strb;
  logic [4*W-1:0] lanes_hi, lanes_lo;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  oport_router #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode_fld(mode_fld), .cplx_en(cplx_en),
    .cplx_sel(cplx_sel), .dbl_rate(dbl_rate), .strb_en(strb_en),
    .in_valid(in_valid), .sum_re(sum_re), .sum_im(sum_im),
    .cas_re(cas_re), .cas_im(cas_im), .port_a_in(port_a_in),
    .port_b_in(port_b_in), .casc_re_in(casc_re_in), .casc_im_in(casc_im_in),
    .bidir_oe(bidir_oe), .out_valid(out_valid), .real_strb(real_strb),
    .lanes_hi(lanes_hi), .lanes_lo(lanes_lo)
  );

  function automatic logic [W-1:0] ere(int base, int k);
    return W'(base + k);
  endfunction
  function automatic logic [W-1:0] eim(int base, int k);
    return W'(base + 'h800 + k);
  endfunction

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] hi(int k); return lanes_hi[k*W +: W]; endfunction
  function automatic logic [W-1:0] lo(int k); return lanes_lo[k*W +: W]; endfunction

  task automatic set_mode(logic [1:0] m, logic ce, logic [1:0] cs, logic dr, logic se);
    mode_fld = m; cplx_en = ce; cplx_sel = cs; dbl_rate = dr; strb_en = se;
  endtask

  // drive at negedge, sample after the capturing edge
  task automatic push(int base);
    for (int k = 0; k < 4; k++) begin
      sum_re[k*W +: W] = ere(base, k);
      sum_im[k*W +: W] = eim(base, k);
    end
    in_valid = 1'b1;
    @(posedge clk); #2;
  endtask

  task automatic idle_step();
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    set_mode(2'b01, 1'b0, 2'b00, 1'b0, 1'b1);
    sum_re = '0; sum_im = '0; cas_re = 'hAAAAA; cas_im = 'h55555;
    port_a_in = 'h12345; port_b_in = 'h6789A;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "out_valid in reset", W'(out_valid), 0);
    chk("R1", "bidir_oe in reset", W'(bidir_oe), 0);
    chk("R1", "lane A in reset", hi(0), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1", "strobe after reset", W'(real_strb), 0);
    chk("R1", "lanes lo after reset", lo(3), 0);
    @(negedge clk);
  endtask

  task automatic t_real_imag();
    set_mode(2'b01, 1'b0, 2'b00, 1'b0, 1'b1);
    push('h100);
    chk("R2", "out_valid after sample", W'(out_valid), 1);
    chk("R11", "oe in real mode", W'(bidir_oe), 1);
    for (int k = 0; k < 4; k++) chk("R4", "real lane", hi(k), ere('h100, k));
    chk("R12", "lo equals hi", lo(2), ere('h100, 2));
    chk("R6", "no strobe in real mode", W'(real_strb), 0);
    idle_step();
    set_mode(2'b10, 1'b1, 2'b01, 1'b1, 1'b1);
    @(posedge clk); #2;
    chk("R2", "out_valid low without sample", W'(out_valid), 0);
    chk("R2", "lane held without sample", hi(1), ere('h100, 1));
    @(negedge clk);
    push('h200);
    for (int k = 0; k < 4; k++) chk("R10", "imag lane with extra bits set", hi(k), eim('h200, k));
    chk("R10", "lo equals hi in imag mode", lo(3), eim('h200, 3));
    idle_step();
  endtask

  task automatic t_cascade();
    set_mode(2'b00, 1'b1, 2'b10, 1'b1, 1'b1);
    chk("R3", "no forward while oe high", casc_re_in, 0);
    push('h300);
    chk("R3", "oe low in cascade", W'(bidir_oe), 0);
    chk("R3", "lane A zero", hi(0), 0);
    chk("R3", "lane B zero", hi(1), 0);
    chk("R3", "lane C cascade re", hi(2), 'hAAAAA);
    chk("R3", "lane D cascade im", hi(3), 'h55555);
    chk("R3", "forward re", casc_re_in, 'h12345);
    chk("R3", "forward im", casc_im_in, 'h6789A);
    idle_step();
    set_mode(2'b01, 1'b0, 2'b00, 1'b0, 1'b0);
    #1;
    chk("R3", "no forward outside cascade", casc_im_in, 0);
    @(posedge clk); #2;
    chk("R11", "oe back after cascade", W'(bidir_oe), 1);
    @(negedge clk);
  endtask

  task automatic t_mux();
    // start in real mode for a sample, then switch mid-stream
    set_mode(2'b01, 1'b0, 2'b00, 1'b0, 1'b1);
    push('h400);
    @(negedge clk);
    set_mode(2'b11, 1'b0, 2'b00, 1'b0, 1'b1);
    for (int s = 0; s < 5; s++) begin
      push('h1000 + s * 'h10);
      for (int k = 0; k < 4; k++)
        chk(s == 0 ? "R7" : "R5", "interleave lane", hi(k),
            (s % 2 == 0) ? ere('h1000 + s * 'h10, k) : eim('h1000 + s * 'h10, k));
      chk("R5", "strobe marks real", W'(real_strb), W'(s % 2 == 0));
      @(negedge clk);
    end
    // now phase is imaginary; leave and return: restart real
    in_valid = 1'b0;
    set_mode(2'b10, 1'b0, 2'b00, 1'b0, 1'b1);
    @(negedge clk);
    set_mode(2'b11, 1'b0, 2'b00, 1'b0, 1'b1);
    push('h2000);
    chk("R7", "restart real lane A", hi(0), ere('h2000, 0));
    chk("R7", "restart strobe", W'(real_strb), 1);
    @(negedge clk);
    strb_en = 1'b0;
    push('h2100);
    chk("R5", "second is imaginary", hi(3), eim('h2100, 3));
    @(negedge clk);
    push('h2200);
    chk("R6", "strobe off when disabled", W'(real_strb), 0);
    chk("R5", "third is real", hi(1), ere('h2200, 1));
    idle_step();
  endtask

  task automatic t_dbl();
    set_mode(2'b01, 1'b0, 2'b00, 1'b1, 1'b1);
    for (int s = 0; s < 2; s++) begin
      push('h3000 + s);
      for (int k = 0; k < 4; k++) begin
        chk("R8", "double-rate hi", hi(k), ere('h3000 + s, k));
        chk("R8", "double-rate lo", lo(k), eim('h3000 + s, k));
      end
      chk("R6", "no strobe in double rate", W'(real_strb), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_cpx();
    logic [W-1:0] e [4];
    for (int v = 0; v < 4; v++) begin
      set_mode(2'b01, 1'b1, 2'(v), 1'b1, 1'b1);
      push('h4000 + v * 'h40);
      if (v == 1) begin
        e[0] = ere('h4040, 0); e[1] = eim('h4040, 0); e[2] = ere('h4040, 2); e[3] = ere('h4040, 3);
      end else if (v == 2) begin
        e[0] = ere('h4080, 0); e[1] = ere('h4080, 1); e[2] = ere('h4080, 2); e[3] = eim('h4080, 2);
      end else begin
        e[0] = ere('h4000 + v * 'h40, 0); e[1] = eim('h4000 + v * 'h40, 0);
        e[2] = ere('h4000 + v * 'h40, 2); e[3] = eim('h4000 + v * 'h40, 2);
      end
      for (int k = 0; k < 4; k++) chk("R9", "complex lane", hi(k), e[k]);
      chk("R10", "complex beats double rate", lo(3), e[3]);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_real_imag();
        t_cascade();
        t_mux();
        t_dbl();
        t_cpx();
      end
      begin
        #(200000 * 8);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule